// File: doc/BRIEF.md
# Sequential Shift-Add Unsigned Multiplier

This block multiplies two unsigned W-bit integers over W clock cycles and returns the full 2W-bit product. It keeps the multiplicand fixed in a W-bit register and uses a single W-bit adder. One 2W-bit accumulator register holds the growing partial sum in its upper half. At load time, its lower half holds the multiplier. Each cycle, the lowest accumulator bit decides whether the multiplicand is added to the upper half. The sum, including its carry-out, is then written back shifted right by one place. This uses up one multiplier bit and retires one settled product bit into the lower half.

A caller holds `go` high for a cycle while the unit is idle, with both operands valid. `busy` is high for exactly W cycles. `done` then pulses for one cycle, and `product` keeps its value until the next accepted request. The default width is 32. The block works unchanged at small widths, so it can be checked exhaustively.

Top module: `seqmul`

## Requirements
- R1: While synchronous reset is high, and in the cycle after it is released, `busy` and `done` are 0 and `product` is all zeros.
- R2: When `go` is 1 and `busy` is 0 at a rising edge, the next cycle shows `busy` = 1 and `product` = {W zeros, multiplier}. The multiplicand is captured at the same edge.
- R3: After i completed steps (1 ≤ i ≤ W), `product` equals (multiplicand × (multiplier mod 2^i)) shifted left by W−i, plus (multiplier shifted right by i). Every step moves the lower half right by one bit.
- R4: `busy` stays 1 for exactly W cycles. In the cycle after the last step, `done` is 1 for one cycle only and `busy` is 0. `busy` and `done` are never both 1.
- R5: When `done` is 1, `product` equals multiplicand × multiplier as an exact 2W-bit unsigned value.
- R6: `go` while `busy` is 1 is ignored: new operand values presented then change neither the timing nor the result.
- R7: While idle with `go` low, `product` keeps its last value.
- R8: The adder's carry-out is kept, so all-ones × all-ones gives (2^W−1)², 225 at W=4.
- R9: At W=4, multiplicand 0010 × multiplier 1011 gives 00010110.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| go | input | 1 | Request a multiply; honoured only when idle |
| mcand | input | W | Multiplicand operand |
| mplier | input | W | Multiplier operand |
| busy | output | 1 | High while steps are being taken |
| done | output | 1 | One-cycle pulse when the product is final |
| product | output | 2W | Accumulator register: partial sums during work, result afterwards |

## Verification
The bench builds the block with W=4. At that width, every one of the 256 operand pairs can be run, together with a reference model that predicts `busy`, `done` and the intermediate accumulator after every clock. This exhaustive sweep covers, with full coverage, the zero, all-ones and power-of-two operands, and the carry out of the top adder bit. Requests raised in the middle of an operation, and idle stretches between operations, are mixed in to exercise the ignore and hold behaviour.

// File: rtl/seqmul.sv
module seqmul #(
  parameter int W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic [W-1:0]     mcand,
  input  logic [W-1:0]     mplier,
  output logic             busy,
  output logic             done,
  output logic [2*W-1:0]   product
);
  localparam int CW = $clog2(W) + 1;

  logic [W-1:0]   mc_q;
  logic [2*W-1:0] acc_q;
  logic [CW-1:0]  step_q;
  logic           busy_q, done_q;
  logic [W-1:0]   addend;
  logic [W:0]     sum;
  logic           last;

  assign addend  = acc_q[0] ? mc_q : '0;
  assign sum     = {1'b0, acc_q[2*W-1:W]} + {1'b0, addend};
  assign last    = (step_q == CW'(W - 1));
  assign busy    = busy_q;
  assign done    = done_q;
  assign product = acc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= '0;
      mc_q   <= '0;
      step_q <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= busy_q && last;
      if (busy_q) begin
        acc_q  <= {sum, acc_q[W-1:1]};
        step_q <= step_q + 1'b1;
        if (last) busy_q <= 1'b0;
      end else if (go) begin
        acc_q  <= {{W{1'b0}}, mplier};
        mc_q   <= mcand;
        step_q <= '0;
        busy_q <= 1'b1;
      end
    end
  end
endmodule

module seqmul_chk #(
  parameter int W = 32,
  parameter int CW = 6
) (
  input logic           clk,
  input logic           rst,
  input logic           go,
  input logic [W-1:0]   mplier,
  input logic           busy,
  input logic           done,
  input logic [2*W-1:0] product,
  input logic [CW-1:0]  step_q
);
  // R4
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (rst) !(busy && done));
  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  // R4
  last_step_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && step_q == CW'(W - 1)) |=> (done && !busy));
  // R2
  load_chk: assert property (@(posedge clk) disable iff (rst)
    (go && !busy) |=> (busy && product == {{W{1'b0}}, $past(mplier)}));
  // R6
  go_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && go && step_q != CW'(W - 1)) |=> busy);
  // R3
  shift_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> (product[W-2:0] == $past(product[W-1:1])));
  // R7
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !go) |=> $stable(product));
endmodule

bind seqmul seqmul_chk #(.W(W), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .go(go), .mplier(mplier), .busy(busy),
  .done(done), .product(product), .step_q(step_q)
);

// File: tb/seqmul_bench.sv
`timescale 1ns/1ps
module seqmul_bench;
  localparam int W = 4;

  logic clk = 1'b0, rst = 1'b1, go = 1'b0;
  logic [W-1:0] mcand = '0, mplier = '0;
  logic busy, done;
  logic [2*W-1:0] product;

  int vectors = 0, fails = 0, cycles = 0;

  seqmul #(.W(W)) u_seqmul (
    .clk(clk), .rst(rst), .go(go), .mcand(mcand), .mplier(mplier),
    .busy(busy), .done(done), .product(product)
  );

  always #4 clk = ~clk;

  // behavioural reference
  bit m_busy, m_done;
  int m_i;
  longint m_a, m_b, m_prod;

  function automatic longint partial(longint a, longint b, int i);
    longint lo;
    lo = b & ((longint'(1) << i) - 1);
    return ((a * lo) << (W - i)) + (b >> i);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_busy <= 0; m_done <= 0; m_i <= 0; m_prod <= 0;
    end else begin
      m_done <= 0;
      if (m_busy) begin
        m_i    <= m_i + 1;
        m_prod <= partial(m_a, m_b, m_i + 1);
        if (m_i + 1 == W) begin m_busy <= 0; m_done <= 1; end
      end else if (go) begin
        m_busy <= 1; m_i <= 0; m_a <= longint'(mcand); m_b <= longint'(mplier);
        m_prod <= longint'(mplier);
      end
    end
  end

  task automatic chk(string req, longint act, longint exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R4 busy", longint'(busy), longint'(m_busy));
    chk("R4 done", longint'(done), longint'(m_done));
    chk("R3 product", longint'(product), m_prod);
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    cycles++;
    compare_all();
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  task automatic run(int a, int b, bit disturb);
    int n;
    mcand = W'(a); mplier = W'(b); go = 1'b1;
    tick();
    chk("R2 busy after go", longint'(busy), 1);
    chk("R2 load", longint'(product), longint'(b));
    if (disturb) begin
      mcand = ~W'(a); mplier = ~W'(b); go = 1'b1;
    end else go = 1'b0;
    n = 0;
    while (!done && n < W + 3) begin
      tick();
      go = 1'b0;
      n++;
    end
    chk("R4 busy length", longint'(n), longint'(W));
    chk("R5 result", longint'(product), longint'(a) * longint'(b));
    if (a == (1 << W) - 1 && b == (1 << W) - 1)
      chk("R8 carry", longint'(product), 225);
    if (a == 2 && b == 11)
      chk("R9 example", longint'(product), 8'b00010110);
    if (disturb) chk("R6 go ignored", longint'(product), longint'(a) * longint'(b));
    go = 1'b0;
    tick();
    chk("R7 hold", longint'(product), longint'(a) * longint'(b));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy", longint'(busy), 0);
    chk("R1 done", longint'(done), 0);
    chk("R1 product", longint'(product), 0);
    rst = 1'b0;
    tick();
    chk("R1 product after release", longint'(product), 0);
    run(2, 11, 1'b0);
    run(15, 15, 1'b0);
    run(0, 15, 1'b1);
    for (int a = 0; a < (1 << W); a++)
      for (int b = 0; b < (1 << W); b++)
        run(a, b, ((a + b) % 3) == 0);
    repeat (3) tick();
    chk("R7 idle hold", longint'(product), 225);
    finish_run();
  end

  always @(posedge clk) begin
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected below 100000", cycles);
      finish_run();
    end
  end
endmodule